// File: doc/BRIEF.md
# Register Script Playback Sequencer

After reset, an external radio transceiver must be brought up by a long, ordered series of register accesses. This block plays that series back from an on-chip program ROM. It steps through the ROM one entry at a time, strictly in address order, and runs each entry as one of four command kinds. A register write and a register read-and-compare are each handed to an external SPI master as one request/acknowledge transaction. A timed pause lasts a given number of milliseconds. A calibration poll keeps re-reading a status register until a chosen bit reads 1, and gives up after a timeout measured in milliseconds.

A single-cycle `start` pulse launches the program from entry 0. `busy` stays high while the program runs. An end marker stops the program cleanly and raises `done`. A failed compare or an expired poll stops the program, raises `err` and latches the index of the failing entry in `fail_idx`. A millisecond time base comes from the system clock through a prescaler that is set by a parameter. The block also enforces one rule of its own: writing the clock-enable value 0x07 to register 0x009 is always followed by a settling pause of 20 ms, even when the program holds no wait command at that point. The ROM is synchronous and sits outside the block. Its data is valid one clock after `rom_addr` changes.

Top module: `scseq_top`

## Requirements
- R1: Each 20-bit program word is split into fields. Bits [19:18] hold the opcode: 00 is register write, 01 is read-and-compare, 10 is timed wait, 11 is calibration poll. Bits [17:8] hold a 10-bit register address, so addresses up to 0x3FF are reachable. Bits [7:0] hold the data byte. A wait takes its millisecond count from bits [15:0]. A wait whose count is 0 is the end marker.
- R2: A `start` pulse while idle makes `busy` high on the next cycle, clears `done` and `err`, and fetches entry 0. A `start` pulse while `busy` is high has no effect on the running program.
- R3: A write raises `spi_req` with `spi_we`=1 and drives the word's address and data on `spi_addr` and `spi_wdata`. All request fields stay unchanged until `spi_ack`. Exactly one transaction is issued per write.
- R4: A read-and-compare raises `spi_req` with `spi_we`=0 and compares the returned byte with the word's data field. If they match, the program continues. If they differ, the program stops: `err`=1, `fail_idx` holds the entry index, `busy` falls and no further request is issued.
- R5: A wait of N ms holds the next request back for at least N·CYC_PER_MS cycles, counted from the previous acknowledge, and for at most N·CYC_PER_MS+10 cycles.
- R6: An acknowledged write of data 0x07 to address 0x009 is followed by a 20 ms pause before the next request. A write of any other value to 0x009 adds no pause.
- R7: A poll reads the word's address with `spi_we`=0. The bit index is in data bits [2:0]. The poll completes on the first read where that bit is 1. Until then the read is repeated, and `spi_req` drops for at least one cycle after every acknowledge.
- R8: If a poll has not completed once POLL_TIMEOUT_MS milliseconds (default 2000) have passed since it began, the program stops with `err`=1 and `fail_idx` set to the poll's index. Later entries are not executed.
- R9: Entries run strictly in ROM order. The program index is 12 bits wide. While running, `rom_addr` only ever advances by one.
- R10: The end marker sets `done`=1 and `busy`=0, and `err` stays 0. A new `start` replays the program from entry 0.
- R11: While `rst` is high and after it is released, `busy`, `done`, `err` and `spi_req` are 0 and `fail_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that launches the program |
| rom_addr | output | 12 | Index of the program entry being fetched |
| rom_data | input | 20 | Program word, valid one cycle after `rom_addr` |
| spi_req | output | 1 | Transaction request to the SPI master |
| spi_we | output | 1 | 1 for a write, 0 for a read |
| spi_addr | output | 10 | Register address of the transaction |
| spi_wdata | output | 8 | Write byte (for reads, the data field of the word) |
| spi_ack | input | 1 | Transaction complete, single-cycle pulse |
| spi_rdata | input | 8 | Read byte, valid with `spi_ack` |
| busy | output | 1 | Program running |
| done | output | 1 | Program reached its end marker |
| err | output | 1 | Program stopped on a compare mismatch or a poll timeout |
| fail_idx | output | 12 | Index of the entry that stopped the program |

## Verification
Each non-pausing entry costs a fixed pipeline of cycles. The acknowledge is seen on one edge, the fetch takes one cycle and the decode takes one, so the next request appears four edges after the acknowledge. A wait of N ms adds N·CYC_PER_MS cycles plus one cycle for the expiry check. The bench logs, in the responder, the cycle of every acknowledge and every first request cycle. It then checks each gap against a window that starts at the exact lower bound and allows a few pipeline cycles above it. This way no check depends on a single edge. The `done`, `err` and `fail_idx` results change on the same edge that drops `busy`, so they are read at the falling edge after `busy` is seen low. The poll timeout is checked as elapsed cycles from `start` to the end of the program, against the full 2000 ms bound.

// File: rtl/scseq_pkg.sv
package scseq_pkg;

    localparam int OPC_W  = 2;
    localparam int REGA_W = 10;
    localparam int BYTE_W = 8;
    localparam int WORD_W = OPC_W + REGA_W + BYTE_W;
    localparam int ARG_W  = 16;

    typedef enum logic [OPC_W-1:0] {
        OPC_WRITE = 2'b00,
        OPC_CHECK = 2'b01,
        OPC_PAUSE = 2'b10,
        OPC_POLL  = 2'b11
    } opc_e;

    typedef struct packed {
        opc_e              opc;
        logic [REGA_W-1:0] rega;
        logic [BYTE_W-1:0] val;
    } word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_XFER,
        ST_RETRY,
        ST_HOLD
    } state_e;

    // millisecond argument of a wait word: low 16 bits of the word
    function automatic logic [ARG_W-1:0] word_arg(word_t w);
        return {w.rega[7:0], w.val};
    endfunction

    function automatic logic is_end(word_t w);
        return (w.opc == OPC_PAUSE) && (word_arg(w) == '0);
    endfunction

    function automatic logic bit_set(logic [BYTE_W-1:0] rd, logic [2:0] sel);
        return rd[sel];
    endfunction

endpackage

// File: rtl/scseq_tick.sv
module scseq_tick #(
    parameter int CYC_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CYC_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scseq_mstimer.sv
module scseq_mstimer #(
    parameter int MS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    input  logic [MS_W-1:0] limit,
    output logic            expired
);
    logic [MS_W-1:0] elapsed;

    assign expired = (elapsed >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            elapsed <= '0;
        end else if (tick && (elapsed != '1)) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/scseq_ctrl.sv
module scseq_ctrl
    import scseq_pkg::*;
#(
    parameter int               IDX_W           = 12,
    parameter int               MS_W            = 16,
    parameter logic [REGA_W-1:0] CLKEN_ADDR     = 10'h009,
    parameter logic [BYTE_W-1:0] CLKEN_DATA     = 8'h07,
    parameter int               CLKEN_WAIT_MS   = 20,
    parameter int               POLL_TIMEOUT_MS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [IDX_W-1:0]  rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              spi_req,
    output logic              spi_we,
    output logic [REGA_W-1:0] spi_addr,
    output logic [BYTE_W-1:0] spi_wdata,
    input  logic              spi_ack,
    input  logic [BYTE_W-1:0] spi_rdata,
    output logic              tmr_clr,
    output logic [MS_W-1:0]   tmr_limit,
    input  logic              tmr_expired,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  fail_idx
);
    state_e           state;
    logic [IDX_W-1:0] pc;
    word_t            cur;
    word_t            fetched;
    logic [MS_W-1:0]  limit_q;
    logic             done_q;
    logic             err_q;
    logic [IDX_W-1:0] fidx_q;
    logic             clken_hit;
    logic             poll_ok;
    logic             check_ok;

    assign fetched   = word_t'(rom_data);
    assign clken_hit = (cur.opc == OPC_WRITE) && (cur.rega == CLKEN_ADDR)
                       && (cur.val == CLKEN_DATA);
    assign poll_ok   = bit_set(spi_rdata, cur.val[2:0]);
    assign check_ok  = (spi_rdata == cur.val);

    // timer restarts on entry to any timed section
    always_comb begin
        tmr_clr = 1'b0;
        if (state == ST_DECODE) begin
            if (fetched.opc == OPC_POLL) begin
                tmr_clr = 1'b1;
            end else if ((fetched.opc == OPC_PAUSE) && !is_end(fetched)) begin
                tmr_clr = 1'b1;
            end
        end else if ((state == ST_XFER) && spi_ack && clken_hit) begin
            tmr_clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc      <= '0;
            cur     <= '0;
            limit_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            fidx_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc     <= '0;
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        fidx_q <= '0;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    cur <= fetched;
                    case (fetched.opc)
                        OPC_WRITE, OPC_CHECK: state <= ST_XFER;
                        OPC_POLL: begin
                            limit_q <= MS_W'(POLL_TIMEOUT_MS);
                            state   <= ST_XFER;
                        end
                        default: begin
                            if (is_end(fetched)) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                limit_q <= MS_W'(word_arg(fetched));
                                state   <= ST_HOLD;
                            end
                        end
                    endcase
                end
                ST_XFER: begin
                    if (spi_ack) begin
                        case (cur.opc)
                            OPC_WRITE: begin
                                if (clken_hit) begin
                                    limit_q <= MS_W'(CLKEN_WAIT_MS);
                                    state   <= ST_HOLD;
                                end else begin
                                    pc    <= pc + 1'b1;
                                    state <= ST_FETCH;
                                end
                            end
                            OPC_CHECK: begin
                                if (check_ok) begin
                                    pc    <= pc + 1'b1;
                                    state <= ST_FETCH;
                                end else begin
                                    err_q  <= 1'b1;
                                    fidx_q <= pc;
                                    state  <= ST_IDLE;
                                end
                            end
                            default: begin
                                if (poll_ok) begin
                                    pc    <= pc + 1'b1;
                                    state <= ST_FETCH;
                                end else if (tmr_expired) begin
                                    err_q  <= 1'b1;
                                    fidx_q <= pc;
                                    state  <= ST_IDLE;
                                end else begin
                                    state <= ST_RETRY;
                                end
                            end
                        endcase
                    end
                end
                ST_RETRY: begin
                    state <= ST_XFER;
                end
                ST_HOLD: begin
                    if (tmr_expired) begin
                        pc    <= pc + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rom_addr  = pc;
    assign spi_req   = (state == ST_XFER);
    assign spi_we    = (cur.opc == OPC_WRITE);
    assign spi_addr  = cur.rega;
    assign spi_wdata = cur.val;
    assign tmr_limit = limit_q;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign fail_idx  = fidx_q;
endmodule

// File: rtl/scseq_top.sv
module scseq_top
    import scseq_pkg::*;
#(
    parameter int                CYC_PER_MS      = 125000,
    parameter int                IDX_W           = 12,
    parameter int                MS_W            = 16,
    parameter logic [REGA_W-1:0] CLKEN_ADDR      = 10'h009,
    parameter logic [BYTE_W-1:0] CLKEN_DATA      = 8'h07,
    parameter int                CLKEN_WAIT_MS   = 20,
    parameter int                POLL_TIMEOUT_MS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [IDX_W-1:0]  rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              spi_req,
    output logic              spi_we,
    output logic [REGA_W-1:0] spi_addr,
    output logic [BYTE_W-1:0] spi_wdata,
    input  logic              spi_ack,
    input  logic [BYTE_W-1:0] spi_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  fail_idx
);
    logic            tick;
    logic            tmr_clr;
    logic            tmr_expired;
    logic [MS_W-1:0] tmr_limit;

    scseq_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .tick (tick)
    );

    scseq_mstimer #(.MS_W(MS_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .tick    (tick),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    scseq_ctrl #(
        .IDX_W           (IDX_W),
        .MS_W            (MS_W),
        .CLKEN_ADDR      (CLKEN_ADDR),
        .CLKEN_DATA      (CLKEN_DATA),
        .CLKEN_WAIT_MS   (CLKEN_WAIT_MS),
        .POLL_TIMEOUT_MS (POLL_TIMEOUT_MS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .rom_addr    (rom_addr),
        .rom_data    (rom_data),
        .spi_req     (spi_req),
        .spi_we      (spi_we),
        .spi_addr    (spi_addr),
        .spi_wdata   (spi_wdata),
        .spi_ack     (spi_ack),
        .spi_rdata   (spi_rdata),
        .tmr_clr     (tmr_clr),
        .tmr_limit   (tmr_limit),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .fail_idx    (fail_idx)
    );
endmodule

// File: rtl/scseq_chk.sv
module scseq_chk #(
    parameter int          CYC_PER_MS    = 125000,
    parameter int          IDX_W         = 12,
    parameter logic [9:0]  CLKEN_ADDR    = 10'h009,
    parameter logic [7:0]  CLKEN_DATA    = 8'h07,
    parameter int          CLKEN_WAIT_MS = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [IDX_W-1:0] rom_addr,
    input logic             spi_req,
    input logic             spi_we,
    input logic [9:0]       spi_addr,
    input logic [7:0]       spi_wdata,
    input logic             spi_ack,
    input logic             busy,
    input logic             done,
    input logic             err
);
    localparam int GAP_MIN = CLKEN_WAIT_MS * CYC_PER_MS;

    logic        armed;
    logic [31:0] gap_cnt;

    // counts cycles since an acknowledged clock-enable write
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            armed   <= 1'b0;
            gap_cnt <= '0;
        end else if (spi_req && spi_ack && spi_we && (spi_addr == CLKEN_ADDR)
                     && (spi_wdata == CLKEN_DATA)) begin
            armed   <= 1'b1;
            gap_cnt <= '0;
        end else if (armed && spi_req) begin
            armed <= 1'b0;
        end else if (armed) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done && !err && !spi_req)); // R11
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && !done && !err && rom_addr == '0)); // R2
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst) (spi_req && !spi_ack) |=> (spi_req && $stable(spi_addr) && $stable(spi_we) && $stable(spi_wdata))); // R3
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst) (spi_req && spi_ack) |=> !spi_req); // R7
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) !busy |-> !spi_req); // R4
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> !busy); // R8
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst) !(done && err)); // R10
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy) && !$stable(rom_addr)) |-> (rom_addr == $past(rom_addr) + 1'b1)); // R9
    AST_CLKEN_SETTLE: assert property (@(posedge clk) disable iff (rst) (armed && spi_req) |-> (gap_cnt >= 32'(GAP_MIN))); // R6
endmodule

bind scseq_top scseq_chk #(
    .CYC_PER_MS    (CYC_PER_MS),
    .IDX_W         (IDX_W),
    .CLKEN_ADDR    (CLKEN_ADDR),
    .CLKEN_DATA    (CLKEN_DATA),
    .CLKEN_WAIT_MS (CLKEN_WAIT_MS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rom_addr  (rom_addr),
    .spi_req   (spi_req),
    .spi_we    (spi_we),
    .spi_addr  (spi_addr),
    .spi_wdata (spi_wdata),
    .spi_ack   (spi_ack),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/tb_scseq_top.sv
module tb_scseq_top;
    localparam int CYC  = 10;
    localparam int WDOG = 190000;

    typedef struct packed {
        logic [19:0] cmd;
        logic [7:0]  rsp;
        logic        we;
        logic [9:0]  addr;
        logic [7:0]  wd;
        logic        bad;
    } vec_t;

    // single-command programs: word, responder byte, expected request, expected error
    localparam vec_t VECS [0:5] = '{
        '{20'h2A60E, 8'h00, 1'b1, 10'h2A6, 8'h0E, 1'b0},
        '{20'h3DF01, 8'h00, 1'b1, 10'h3DF, 8'h01, 1'b0},
        '{20'h45E80, 8'h80, 1'b0, 10'h05E, 8'h80, 1'b0},
        '{20'h45E80, 8'h81, 1'b0, 10'h05E, 8'h80, 1'b1},
        '{20'hC5E07, 8'h80, 1'b0, 10'h05E, 8'h07, 1'b0},
        '{20'hD2300, 8'h01, 1'b0, 10'h123, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] rom_addr;
    logic [19:0] rom_data;
    logic        spi_req, spi_we, spi_ack;
    logic [9:0]  spi_addr;
    logic [7:0]  spi_wdata, spi_rdata;
    logic        busy, done, err;
    logic [11:0] fail_idx;

    logic [19:0] prog [0:63];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_log = 0;
    int log_base = 0;
    int poll_reads = 0;
    int poll_base = 0;
    int poll_need = 0;
    logic       poll_en = 1'b0;
    logic [9:0] poll_addr = 10'h05E;
    logic [7:0] rsp_val = 8'h00;
    logic [7:0] rd_value;
    int rsp_cnt = 0;
    int req_start = 0;
    logic [9:0] log_addr [0:63];
    logic       log_we   [0:63];
    logic [7:0] log_wd   [0:63];
    int         log_ack  [0:63];
    int         log_req  [0:63];

    always #4 clk = ~clk;

    scseq_top #(.CYC_PER_MS(CYC)) dut (
        .clk(clk), .rst(rst), .start(start),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .spi_req(spi_req), .spi_we(spi_we), .spi_addr(spi_addr),
        .spi_wdata(spi_wdata), .spi_ack(spi_ack), .spi_rdata(spi_rdata),
        .busy(busy), .done(done), .err(err), .fail_idx(fail_idx)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rom_data <= prog[rom_addr[5:0]];

    assign rd_value = (poll_en && spi_addr == poll_addr)
                    ? (((poll_reads - poll_base) >= poll_need) ? 8'h80 : 8'h00)
                    : rsp_val;

    // responder: acknowledges each request on its second cycle
    always @(posedge clk) begin
        if (rst) begin
            spi_ack <= 1'b0;
            spi_rdata <= 8'h00;
            rsp_cnt <= 0;
        end else if (spi_ack) begin
            spi_ack <= 1'b0;
            rsp_cnt <= 0;
        end else if (spi_req) begin
            if (rsp_cnt == 0) begin
                req_start <= cyc;
                rsp_cnt <= 1;
            end else begin
                spi_ack <= 1'b1;
                spi_rdata <= rd_value;
                log_addr[n_log[5:0]] <= spi_addr;
                log_we[n_log[5:0]] <= spi_we;
                log_wd[n_log[5:0]] <= spi_wdata;
                log_ack[n_log[5:0]] <= cyc;
                log_req[n_log[5:0]] <= req_start;
                n_log <= n_log + 1;
                if (poll_en && spi_addr == poll_addr) poll_reads <= poll_reads + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int li(input int k);
        return (log_base + k) & 63;
    endfunction

    function automatic logic [19:0] wr(input logic [9:0] a, input logic [7:0] d);
        return {2'b00, a, d};
    endfunction

    function automatic logic [19:0] rdc(input logic [9:0] a, input logic [7:0] d);
        return {2'b01, a, d};
    endfunction

    function automatic logic [19:0] pause(input int ms);
        return {4'b1000, ms[15:0]};
    endfunction

    function automatic logic [19:0] poll(input logic [9:0] a, input logic [2:0] b);
        return {2'b11, a, 5'd0, b};
    endfunction

    int t_start = 0;
    int t_end = 0;

    task automatic run(input int lim);
        int n;
        @(negedge clk);
        log_base = n_log;
        poll_base = poll_reads;
        t_start = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < lim) begin
            @(negedge clk);
            n++;
        end
        t_end = cyc;
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < WDOG; k++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) prog[k] = 20'h80000;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 busy", busy, 0);
        check("R11 done", done, 0);
        check("R11 err", err, 0);
        check("R11 req", spi_req, 0);
        check("R11 fail_idx", fail_idx, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 busy after release", busy, 0);

        // vector table: R1 R3 R4 R7 single commands
        foreach (VECS[v]) begin
            prog[0] = VECS[v].cmd;
            prog[1] = 20'h80000;
            rsp_val = VECS[v].rsp;
            run(200);
            check("R1 R3 one transaction", n_log - log_base, 1);
            check("R1 R3 we", log_we[li(0)], VECS[v].we);
            check("R1 R3 addr", log_addr[li(0)], VECS[v].addr);
            if (VECS[v].we) check("R3 wdata", log_wd[li(0)], VECS[v].wd);
            check("R4 R7 err", err, VECS[v].bad);
            check("R10 done", done, !VECS[v].bad);
            check("R4 busy low", busy, 0);
        end

        // R5 timed wait of 5 ms
        prog[0] = wr(10'h100, 8'h11); prog[1] = pause(5);
        prog[2] = wr(10'h101, 8'h22); prog[3] = 20'h80000;
        run(500);
        check("R5 count", n_log - log_base, 2);
        check("R5 gap low", int'(log_req[li(1)] - log_ack[li(0)] >= 5*CYC), 1);
        check("R5 gap high", int'(log_req[li(1)] - log_ack[li(0)] <= 5*CYC + 10), 1);

        // R6 clock-enable write adds 20 ms
        prog[0] = wr(10'h009, 8'h07); prog[1] = wr(10'h00A, 8'h02); prog[2] = 20'h80000;
        run(1000);
        check("R6 gap low", int'(log_req[li(1)] - log_ack[li(0)] >= 20*CYC), 1);
        check("R6 gap high", int'(log_req[li(1)] - log_ack[li(0)] <= 20*CYC + 10), 1);
        prog[0] = wr(10'h009, 8'h05);
        run(1000);
        check("R6 other value no pause", int'(log_req[li(1)] - log_ack[li(0)] < 20*CYC), 1);

        // R7 poll with three misses
        poll_en = 1'b1; poll_need = 3;
        prog[0] = poll(10'h05E, 3'd7); prog[1] = wr(10'h044, 8'h18); prog[2] = 20'h80000;
        run(1000);
        check("R7 reads plus write", n_log - log_base, 5);
        check("R7 final write addr", log_addr[li(4)], 10'h044);
        check("R7 done", done, 1);
        check("R7 err", err, 0);

        // R9 strict order
        for (int k = 0; k < 6; k++) prog[k] = wr(10'h200 + 10'(k), 8'(k));
        prog[6] = 20'h80000;
        run(500);
        check("R9 count", n_log - log_base, 6);
        for (int k = 0; k < 6; k++) check("R9 order", log_addr[li(k)], 10'h200 + k);
        check("R9 index width", $bits(rom_addr), 12);

        // R10 restart replays from entry 0
        run(500);
        check("R10 replay first", log_addr[li(0)], 10'h200);
        check("R10 replay count", n_log - log_base, 6);

        // R2 start during a run is ignored
        prog[0] = wr(10'h300, 8'h01); prog[1] = pause(3);
        prog[2] = wr(10'h301, 8'h02); prog[3] = 20'h80000;
        @(negedge clk);
        log_base = n_log;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        check("R2 busy during wait", busy, 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        check("R2 no restart count", n_log - log_base, 2);
        check("R2 second write", log_addr[li(1)], 10'h301);

        // R4 mismatch at index 2 halts the program
        rsp_val = 8'h54;
        prog[0] = wr(10'h010, 8'h01); prog[1] = wr(10'h011, 8'h02);
        prog[2] = rdc(10'h012, 8'h55); prog[3] = wr(10'h013, 8'h03); prog[4] = 20'h80000;
        run(500);
        check("R4 err", err, 1);
        check("R4 fail_idx", fail_idx, 2);
        check("R4 no later write", n_log - log_base, 3);
        check("R4 done low", done, 0);

        // R2 a new start clears err
        prog[2] = wr(10'h012, 8'h55);
        run(500);
        check("R2 err cleared", err, 0);
        check("R2 done set", done, 1);

        // R8 poll timeout after 2000 ms
        poll_need = 1000000;
        prog[0] = wr(10'h020, 8'h01); prog[1] = poll(10'h05E, 3'd7);
        prog[2] = wr(10'h021, 8'h02); prog[3] = 20'h80000;
        run(30000);
        check("R8 err", err, 1);
        check("R8 fail_idx", fail_idx, 1);
        check("R8 done low", done, 0);
        check("R8 busy low", busy, 0);
        check("R8 elapsed", int'((t_end - t_start) >= 2000*CYC), 1);
        check("R8 last access is poll", log_addr[(n_log - 1) & 63], 10'h05E);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule